// File: doc/BRIEF.md
# FSK Alarm Address Transmitter

This block is the digital core of one remote alarm station. After reset it waits through an arming window during which the detector input is ignored, so an installer can leave the site. Once armed, the detector is sampled on a slow bit tick. The first closed sample sets a sticky alarm flag. That flag passes through a short delay stage and then enables the transmitter. Before that, the station stays quiet and draws little power. The power indicator is lit while no alarm is held.

While enabled, the block sends its fixed 7-bit station address as a 10-bit serial word from a rotating shift register. The register is reloaded in parallel whenever transmission is off. Each serial bit steers a two-way selector between two square-wave tones, both made by the same divider that makes the bit tick. Air time is shared with other stations by alternating equal send and silent periods. The address is sent at the start of each send period.

Top module: `alarm_fsk_tx`

## Requirements
- R1: While reset is held, tx_en_o is 0, tone_o is 0, data_o is 1 and pwr_led_o is 1. pwr_led_o stays 1 until an alarm is latched and is 0 from then on.
- R2: For the first ARM_TICKS bit ticks after reset, the detector is ignored. A detector pulse that ends inside this window never starts a transmission. A detector held closed across the end of the window triggers about (ARM_TICKS+DELAY_TICKS+1) bit periods after reset.
- R3: After arming, a detector closure seen on a bit tick latches the alarm until the next reset. Opening the detector later does not stop the bursts.
- R4: tx_en_o rises DELAY_TICKS bit ticks after the alarm latches. Measured from the detector closure, this is between DELAY_TICKS*BIT_CLKS and (DELAY_TICKS+1)*BIT_CLKS+4 clock cycles.
- R5: Each send period begins with a 10-bit word on data_o, each bit lasting BIT_CLKS cycles, in this order: a start bit of 0, the seven address bits least significant first, an even-parity bit equal to the XOR of the address bits, and a stop bit of 1. data_o then stays 1 for the rest of the period.
- R6: While tx_en_o is 1, tone_o toggles every TONE1_HALF clocks when the current bit is 1 and every TONE2_HALF clocks when it is 0.
- R7: After the first enable, tx_en_o is 1 for BURST_TICKS bit periods and 0 for the next BURST_TICKS, and this pattern repeats. Each send period restarts the word from its start bit.
- R8: Whenever tx_en_o is 0, tone_o is 0 and data_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| detect_i | input | 1 | Detector contact, 1 = closed (event) |
| tone_o | output | 1 | Selected FSK tone toward the RF modulator |
| data_o | output | 1 | Serial address word, idle level 1 |
| tx_en_o | output | 1 | Transmit enable for the RF stage |
| pwr_led_o | output | 1 | Power indicator, lit while no alarm is held |

## Verification
The detector is driven with four patterns. The first is a pulse that ends inside the arming window; it must not trigger, which separates a working hold-off from an input that is sampled at once. The second is a closure after arming that opens again right after the first enable; it shows the onset delay, and the bursts that follow show the latch is sticky. The third is a level held closed straight through arming, which separates an edge-sensitive trigger from a level-sensitive one. The fourth is a detector that stays open after a second reset, which must keep the station silent. During the first send period, each bit's level and the spacing of tone transitions inside it are measured. These checks tell the frame order, the parity and the tone mapping apart. A table of period-by-period enable values covers the send and silent schedule.

// File: rtl/alarm_tx_pkg.sv
package alarm_tx_pkg;

    localparam int ADDR_W    = 7;
    localparam int FRAME_LEN = ADDR_W + 3;

    typedef enum logic {
        PH_SEND = 1'b0,
        PH_GAP  = 1'b1
    } burst_phase_e;

    // Word as shifted out from bit 0: start, address LSB first, even parity, stop
    function automatic logic [FRAME_LEN-1:0] build_frame(input logic [ADDR_W-1:0] addr);
        logic [FRAME_LEN-1:0] f;
        f                = '0;
        f[0]             = 1'b0;
        f[ADDR_W:1]      = addr;
        f[ADDR_W+1]      = ^addr;
        f[FRAME_LEN-1]   = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/alarm_tx_divider.sv
module alarm_tx_divider #(
    parameter int TONE1_HALF = 3,
    parameter int TONE2_HALF = 5,
    parameter int BIT_CLKS   = 24
) (
    input  logic clk,
    input  logic rst_n,
    output logic tone1_o,
    output logic tone2_o,
    output logic tick_o
);

    localparam int BW = $clog2(BIT_CLKS);

    logic [1:0] tone_w;

    // One free-running square wave per tone
    for (genvar g = 0; g < 2; g++) begin : g_tone
        localparam int HALF_N = (g == 0) ? TONE1_HALF : TONE2_HALF;
        localparam int CW     = (HALF_N > 1) ? $clog2(HALF_N) : 1;

        typedef struct packed {
            logic [CW-1:0] cnt;
            logic          lvl;
        } tone_t;

        tone_t t_d, t_q;

        always_comb begin
            t_d     = t_q;
            t_d.cnt = t_q.cnt + 1'b1;
            if (t_q.cnt == CW'(HALF_N - 1)) begin
                t_d.cnt = '0;
                t_d.lvl = ~t_q.lvl;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) t_q <= '0;
            else        t_q <= t_d;
        end

        assign tone_w[g] = t_q.lvl;
    end

    assign tone1_o = tone_w[0];
    assign tone2_o = tone_w[1];

    // Bit tick: one-cycle pulse every BIT_CLKS cycles
    typedef struct packed {
        logic [BW-1:0] cnt;
        logic          tick;
    } div_t;

    div_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        s_d.cnt  = s_q.cnt + 1'b1;
        if (s_q.cnt == BW'(BIT_CLKS - 1)) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = s_q.tick;

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R5

endmodule

// File: rtl/alarm_tx_ctrl.sv
module alarm_tx_ctrl #(
    parameter int ARM_TICKS   = 8,
    parameter int DELAY_TICKS = 3,
    parameter int BURST_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic detect_i,
    output logic alarm_o,
    output logic tx_en_o
);
    import alarm_tx_pkg::*;

    localparam int AW  = $clog2(ARM_TICKS + 1);
    localparam int BCW = $clog2(BURST_TICKS);

    typedef struct packed {
        logic [1:0]             sync;
        logic [AW-1:0]          arm_cnt;
        logic                   armed;
        logic                   latch;
        logic [DELAY_TICKS-1:0] dly;
        logic [BCW-1:0]         bcnt;
        burst_phase_e           phase;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  go;

    assign go = s_q.dly[DELAY_TICKS-1];

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], detect_i};
        if (tick_i) begin
            // Arming hold-off, then sticky detector capture
            if (!s_q.armed) begin
                if (s_q.arm_cnt == AW'(ARM_TICKS - 1)) s_d.armed = 1'b1;
                s_d.arm_cnt = s_q.arm_cnt + 1'b1;
            end else if (s_q.sync[1]) begin
                s_d.latch = 1'b1;
            end
            // Trigger delay chain
            s_d.dly = DELAY_TICKS'({s_q.dly, s_q.latch});
            // Send / silent schedule
            if (!go) begin
                s_d.bcnt  = '0;
                s_d.phase = PH_SEND;
            end else if (s_q.bcnt == BCW'(BURST_TICKS - 1)) begin
                s_d.bcnt  = '0;
                s_d.phase = (s_q.phase == PH_SEND) ? PH_GAP : PH_SEND;
            end else begin
                s_d.bcnt = s_q.bcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign alarm_o = s_q.latch;
    assign tx_en_o = go && (s_q.phase == PH_SEND);

    AST_ARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.armed |-> !s_q.latch); // R2
    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.latch |=> s_q.latch); // R3
    AST_TX_NEEDS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_o |-> s_q.latch); // R4
    AST_TX_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en_o) |-> $past(tick_i)); // R7

endmodule

// File: rtl/alarm_tx_shifter.sv
module alarm_tx_shifter #(
    parameter logic [6:0] STATION_ADDR = 7'h2D
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic en_i,
    input  logic tone1_i,
    input  logic tone2_i,
    output logic data_o,
    output logic tone_o
);
    import alarm_tx_pkg::*;

    localparam int                   SW    = $clog2(FRAME_LEN + 1);
    localparam logic [FRAME_LEN-1:0] FRAME = build_frame(STATION_ADDR);

    typedef struct packed {
        logic [FRAME_LEN-1:0] sreg;
        logic [SW-1:0]        sent;
    } shf_t;

    shf_t s_d, s_q;
    logic done;

    assign done = (s_q.sent == SW'(FRAME_LEN));

    always_comb begin
        s_d = s_q;
        if (!en_i) begin
            // Load control high: parallel load of the word
            s_d.sreg = FRAME;
            s_d.sent = '0;
        end else if (tick_i && !done) begin
            // Rotate, so the word is back in place after a full pass
            s_d.sreg = {s_q.sreg[0], s_q.sreg[FRAME_LEN-1:1]};
            s_d.sent = s_q.sent + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sreg: FRAME, sent: '0};
        else        s_q <= s_d;
    end

    assign data_o = (en_i && !done) ? s_q.sreg[0] : 1'b1;
    assign tone_o = en_i && (data_o ? tone1_i : tone2_i);

    AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_i) |-> !data_o); // R5
    AST_SENT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sent <= SW'(FRAME_LEN)); // R5
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i) |=> $stable(s_q.sent)); // R5
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (data_o && !tone_o)); // R8

endmodule

// File: rtl/alarm_fsk_tx.sv
module alarm_fsk_tx #(
    parameter logic [6:0] STATION_ADDR = 7'h2D,
    parameter int         TONE1_HALF   = 3,
    parameter int         TONE2_HALF   = 5,
    parameter int         BIT_CLKS     = 24,
    parameter int         ARM_TICKS    = 8,
    parameter int         DELAY_TICKS  = 3,
    parameter int         BURST_TICKS  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic detect_i,
    output logic tone_o,
    output logic data_o,
    output logic tx_en_o,
    output logic pwr_led_o
);

    logic tone1_w;
    logic tone2_w;
    logic tick_w;
    logic alarm_w;
    logic en_w;

    alarm_tx_divider #(
        .TONE1_HALF (TONE1_HALF),
        .TONE2_HALF (TONE2_HALF),
        .BIT_CLKS   (BIT_CLKS)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tone1_o (tone1_w),
        .tone2_o (tone2_w),
        .tick_o  (tick_w)
    );

    alarm_tx_ctrl #(
        .ARM_TICKS   (ARM_TICKS),
        .DELAY_TICKS (DELAY_TICKS),
        .BURST_TICKS (BURST_TICKS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_w),
        .detect_i (detect_i),
        .alarm_o  (alarm_w),
        .tx_en_o  (en_w)
    );

    alarm_tx_shifter #(
        .STATION_ADDR (STATION_ADDR)
    ) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_w),
        .en_i    (en_w),
        .tone1_i (tone1_w),
        .tone2_i (tone2_w),
        .data_o  (data_o),
        .tone_o  (tone_o)
    );

    assign tx_en_o   = en_w;
    assign pwr_led_o = !alarm_w;

endmodule

// File: tb/alarm_fsk_tx_test.sv
module alarm_fsk_tx_test;

    localparam logic [6:0] ADDR  = 7'h2D;
    localparam int         H1    = 3;
    localparam int         H2    = 5;
    localparam int         BIT   = 24;
    localparam int         ARM   = 8;
    localparam int         DLY   = 3;
    localparam int         BURST = 16;
    localparam int         NBITS = 10;
    localparam int         PER   = BURST * BIT;
    // Expected tx_en in the middle-to-late part of periods 0..3
    localparam logic [0:3] PH_EXP = 4'b1010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic detect = 1'b0;
    logic tone, data, tx_en, led;

    int checks = 0;
    int errors = 0;
    int quiet_viol = 0;
    logic watch_quiet = 1'b0;

    alarm_fsk_tx #(
        .STATION_ADDR (ADDR), .TONE1_HALF (H1), .TONE2_HALF (H2),
        .BIT_CLKS (BIT), .ARM_TICKS (ARM), .DELAY_TICKS (DLY), .BURST_TICKS (BURST)
    ) uut (
        .clk (clk), .rst_n (rst_n), .detect_i (detect),
        .tone_o (tone), .data_o (data), .tx_en_o (tx_en), .pwr_led_o (led)
    );

    always #10 clk = ~clk;

    always @(negedge clk)
        if (watch_quiet && (tx_en !== 1'b0 || tone !== 1'b0 || data !== 1'b1))
            quiet_viol++;

    function automatic logic exp_bit(input int i);
        if (i == 0)      return 1'b0;
        else if (i <= 7) return ADDR[i-1];
        else if (i == 8) return ^ADDR;
        else             return 1'b1;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cyc(100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t, el, t1, t2;
        logic prev, dmid;

        // R1: reset state
        wait_cyc(3);
        check("R1", "tx_en in reset", int'(tx_en), 0);
        check("R1", "tone in reset", int'(tone), 0);
        check("R1", "data in reset", int'(data), 1);
        check("R1", "led in reset", int'(led), 1);
        rst_n = 1'b1;

        // R2: pulse inside the arming window is ignored
        wait_cyc(10);
        detect = 1'b1;
        wait_cyc(ARM * BIT - 40);
        detect = 1'b0;
        watch_quiet = 1'b1;
        wait_cyc((ARM + DLY + 4) * BIT);
        watch_quiet = 1'b0;
        check("R2", "activity after arming-window pulse", quiet_viol, 0);
        check("R1", "led with no alarm", int'(led), 1);

        // R4: onset delay from a closure after arming
        detect = 1'b1;
        t = 0;
        while (tx_en !== 1'b1 && t < (DLY + 4) * BIT) begin
            @(negedge clk);
            t++;
        end
        detect = 1'b0;
        check("R4", "onset delay in window",
              int'(t >= DLY * BIT && t <= (DLY + 1) * BIT + 4), 1);
        check("R1", "led off after alarm", int'(led), 0);

        // R5/R6: word content and tone per bit
        for (int i = 0; i < NBITS; i++) begin
            prev = tone;
            t1 = -1;
            t2 = -1;
            dmid = 1'bx;
            for (int k = 1; k < BIT; k++) begin
                @(negedge clk);
                if (tone !== prev) begin
                    if (t1 < 0) t1 = k;
                    else if (t2 < 0) t2 = k;
                end
                prev = tone;
                if (k == BIT / 2) dmid = data;
            end
            check("R5", $sformatf("word bit %0d", i), int'(dmid), int'(exp_bit(i)));
            check("R6", $sformatf("tone half period bit %0d", i), t2 - t1,
                  exp_bit(i) ? H1 : H2);
            @(negedge clk);
        end
        el = NBITS * BIT;

        // R7/R8: send / silent schedule walked from a table
        for (int i = 0; i < 4; i++) begin
            wait_cyc(i * PER + (NBITS + 3) * BIT + BIT / 2 - el);
            el = i * PER + (NBITS + 3) * BIT + BIT / 2;
            check("R7", $sformatf("tx_en period %0d", i), int'(tx_en), int'(PH_EXP[i]));
            check(PH_EXP[i] ? "R5" : "R8", $sformatf("data mark period %0d", i), int'(data), 1);
            if (!PH_EXP[i]) check("R8", $sformatf("tone off period %0d", i), int'(tone), 0);
        end

        // R7/R3: word restarts in a later send period, detector long open
        wait_cyc(4 * PER + BIT / 2 - el);
        for (int b = 0; b < 3; b++) begin
            check("R7", $sformatf("restart bit %0d", b), int'(data), int'(exp_bit(b)));
            check("R3", "still sending after detector opened", int'(tx_en), 1);
            wait_cyc(BIT);
        end

        // R1/R8: reset mid-transmission, then open detector stays silent
        rst_n = 1'b0;
        wait_cyc(3);
        check("R1", "tx_en after re-reset", int'(tx_en), 0);
        check("R1", "led after re-reset", int'(led), 1);
        check("R8", "data after re-reset", int'(data), 1);
        rst_n = 1'b1;
        quiet_viol = 0;
        watch_quiet = 1'b1;
        wait_cyc((ARM + DLY + 6) * BIT);
        watch_quiet = 1'b0;
        check("R8", "idle with open detector", quiet_viol, 0);

        // R2: closure held across the end of arming triggers afterwards
        rst_n = 1'b0;
        detect = 1'b1;
        wait_cyc(3);
        rst_n = 1'b1;
        t = 0;
        while (tx_en !== 1'b1 && t < (ARM + DLY + 4) * BIT) begin
            @(negedge clk);
            t++;
        end
        check("R2", "trigger after held closure",
              int'(t >= (ARM + DLY) * BIT && t <= (ARM + DLY + 2) * BIT), 1);
        detect = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule